// File: doc/BRIEF.md
# Dual-Mode Pulse Accumulator

This block is an 8-bit counter driven by an external input. It has two modes. In event mode it counts one edge direction of the input. In gated-time mode it counts a tick that a divide-by-64 prescaler makes from the system clock. It counts that tick only while the input is at its active level. One polarity bit serves both modes. In event mode it picks the counted edge. In gated mode it picks the active level.

Software reaches the block through a small register port with a two-bit address. Writes are strobed and reads are combinational. Software can preload the count and read it back. Two sticky flags mark a counter wrap and a selected input edge, and each is cleared by writing 1 to its bit. Two interrupt enables route those flags onto a single request line. The input passes through a two-stage synchronizer before any edge is detected. As a result, a pin change reaches the counter about three clock edges later.

Top module: `pulse_acc`

## Requirements
- R1: After reset, every register reads 0 and irq is low. The registers are control (address 0), count (address 1), flags (address 2) and interrupt enables (address 3).
- R2: While the enable bit (control bit 0) is 0, input activity changes neither the count nor any flag, and the prescaler is held at phase zero.
- R3: In event mode (control bit 1 = 0) with polarity (control bit 2) = 0, the count increments once for each falling edge of pin_in and ignores rising edges.
- R4: In event mode with polarity = 1, the count increments once for each rising edge of pin_in and ignores falling edges.
- R5: In gated mode (control bit 1 = 1), the count increments on every 64th enabled clock cycle, counted from the enabling write, whenever pin_in is active. Polarity 0 makes high the active level, and polarity 1 makes low the active level. While pin_in is inactive, the count holds.
- R6: The edge flag (flags bit 1) sets on the selected edge in event mode. In gated mode it sets on the trailing edge of the active interval: falling for polarity 0, rising for polarity 1.
- R7: When an increment takes the count from 0xFF to 0x00, the overflow flag (flags bit 0) sets.
- R8: Writing 1 to a flag bit clears that flag, and writing 0 to it has no effect. If a flag sets in the same cycle as a clearing write, the flag ends up set.
- R9: irq is high exactly when the overflow flag is set with its enable (bit 0 of address 3) set, or when the edge flag is set with its enable (bit 1) set.
- R10: A write to the count loads wdata. In the same cycle, that write takes priority over any increment.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 2 | Register address |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for addr (combinational) |
| pin_in | input | 1 | External asynchronous input |
| irq | output | 1 | Interrupt request |

## Verification
The assertions check, on every cycle:
- the count holds while the block is disabled;
- a count write always wins over an increment;
- the count never moves by more than one step without a write;
- a wrap always leaves the overflow flag set;
- irq stays low when both interrupt enables are clear;
- a prescaler tick only appears when the block is enabled.

Some behaviours only the bench's scenarios can show:
- which edge is counted for each polarity;
- the exact 64-cycle spacing of gated ticks;
- the trailing-edge flag in gated mode;
- flag clearing by writing 1;
- the effect of each interrupt enable.

// File: rtl/pulse_acc_pkg.sv
package pulse_acc_pkg;
  localparam int CNT_W = 8;
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_COUNT = 2'd1;
  localparam logic [1:0] A_FLAGS = 2'd2;
  localparam logic [1:0] A_IEN   = 2'd3;

  function automatic logic [CNT_W-1:0] step_count(input logic [CNT_W-1:0] c);
    return c + {{(CNT_W-1){1'b0}}, 1'b1};
  endfunction

  function automatic logic at_top(input logic [CNT_W-1:0] c);
    return &c;
  endfunction

  // Edge of interest for a given polarity; also the trailing edge in gated mode.
  function automatic logic pick_edge(input logic pol, input logic rise, input logic fall);
    return pol ? rise : fall;
  endfunction
endpackage

// File: rtl/pa_sync.sv
module pa_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic din,
  output logic level,
  output logic rise,
  output logic fall
);
  logic [STAGES-1:0] chain;
  logic              last;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= 1'b0;
          else        chain[0] <= din;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= 1'b0;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) last <= 1'b0;
    else        last <= chain[STAGES-1];

  assign level = chain[STAGES-1];
  assign rise  = level & ~last;
  assign fall  = ~level & last;
endmodule

// File: rtl/pa_tick.sv
module pa_tick #(
  parameter int DIV = 64
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic tick
);
  localparam int W = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  logic [W-1:0] phase;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)            phase <= '0;
    else if (!run)         phase <= '0;
    else if (phase == LAST) phase <= '0;
    else                   phase <= phase + W'(1);

  assign tick = run && (phase == LAST);
endmodule

// File: rtl/pulse_acc.sv
module pulse_acc
  import pulse_acc_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int TICK_DIV    = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [1:0]       addr,
  input  logic [CNT_W-1:0] wdata,
  output logic [CNT_W-1:0] rdata,
  input  logic             pin_in,
  output logic             irq
);
  logic en_q, mode_q, pol_q, ovf_ie_q, edge_ie_q;
  logic ovf_q, edge_q;
  logic [CNT_W-1:0] count_q;

  logic lvl, rise, fall, tick;
  logic cnt_wr, flag_wr, sel_edge, active, inc_evt, edge_evt, wrap_evt;

  pa_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .din(pin_in),
    .level(lvl), .rise(rise), .fall(fall)
  );

  pa_tick #(.DIV(TICK_DIV)) u_tick (
    .clk(clk), .rst_n(rst_n), .run(en_q), .tick(tick)
  );

  assign cnt_wr   = wr_en && (addr == A_COUNT);
  assign flag_wr  = wr_en && (addr == A_FLAGS);
  assign sel_edge = pick_edge(pol_q, rise, fall);
  assign active   = lvl ^ pol_q;
  assign inc_evt  = en_q && (mode_q ? (tick && active) : sel_edge);
  assign edge_evt = en_q && sel_edge;
  assign wrap_evt = inc_evt && at_top(count_q) && !cnt_wr;

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      en_q <= 1'b0; mode_q <= 1'b0; pol_q <= 1'b0;
      ovf_ie_q <= 1'b0; edge_ie_q <= 1'b0;
    end else if (wr_en) begin
      if (addr == A_CTRL) begin
        en_q <= wdata[0]; mode_q <= wdata[1]; pol_q <= wdata[2];
      end
      if (addr == A_IEN) begin
        ovf_ie_q <= wdata[0]; edge_ie_q <= wdata[1];
      end
    end

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)       count_q <= '0;
    else if (cnt_wr)  count_q <= wdata;
    else if (inc_evt) count_q <= step_count(count_q);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ovf_q <= 1'b0; edge_q <= 1'b0;
    end else begin
      if (wrap_evt)                ovf_q <= 1'b1;
      else if (flag_wr && wdata[0]) ovf_q <= 1'b0;
      if (edge_evt)                edge_q <= 1'b1;
      else if (flag_wr && wdata[1]) edge_q <= 1'b0;
    end

  always_comb begin
    rdata = '0;
    unique case (addr)
      A_CTRL:  rdata[2:0] = {pol_q, mode_q, en_q};
      A_COUNT: rdata      = count_q;
      A_FLAGS: rdata[1:0] = {edge_q, ovf_q};
      A_IEN:   rdata[1:0] = {edge_ie_q, ovf_ie_q};
      default: rdata      = '0;
    endcase
  end

  assign irq = (ovf_q && ovf_ie_q) || (edge_q && edge_ie_q);
endmodule

// File: rtl/pulse_acc_checks.sv
module pulse_acc_checks
  import pulse_acc_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             cnt_wr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] count,
  input logic             en,
  input logic             tick,
  input logic             inc,
  input logic             ovf_flag,
  input logic             ovf_ie,
  input logic             edge_ie,
  input logic             irq
);
  assert_disabled_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!en && !cnt_wr) |=> count == $past(count));

  assert_tick_needs_en_R2: assert property (@(posedge clk) disable iff (!rst_n)
    tick |-> en);

  assert_single_step_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (count == $past(count)) || (count == $past(count) + 8'd1));

  assert_wrap_sets_ovf_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (inc && !cnt_wr && count == 8'hFF) |=> (ovf_flag && count == 8'h00));

  assert_irq_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (!ovf_ie && !edge_ie) |-> !irq);

  assert_write_wins_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> count == $past(wdata));
endmodule

bind pulse_acc pulse_acc_checks u_checks (
  .clk(clk), .rst_n(rst_n), .cnt_wr(cnt_wr), .wdata(wdata), .count(count_q),
  .en(en_q), .tick(tick), .inc(inc_evt), .ovf_flag(ovf_q),
  .ovf_ie(ovf_ie_q), .edge_ie(edge_ie_q), .irq(irq)
);

// File: tb/pulse_acc_bench.sv
module pulse_acc_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_en = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'd0;
  logic [7:0] rdata;
  logic       pin_in = 1'b0;
  logic       irq;
  int errors = 0;
  int checks = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  pulse_acc u_pulse_acc (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .pin_in(pin_in), .irq(irq)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got 0x%02h expected 0x%02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; #1; d = rdata;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); pin_in = v; idle(5);
  endtask

  task automatic pulses(input int n);
    for (int i = 0; i < n; i++) begin set_pin(~pin_in); set_pin(~pin_in); end
  endtask

  task automatic t_reset();
    logic [7:0] v;
    for (int a = 0; a < 4; a++) begin rd(2'(a), v); check("R1 reg", v, 8'h00); end
    check("R1 irq", {7'd0, irq}, 8'h00);
  endtask

  task automatic t_disabled();
    logic [7:0] v;
    wr(2'd3, 8'h03);
    pulses(3);
    rd(2'd1, v); check("R2 count", v, 8'h00);
    rd(2'd2, v); check("R2 flags", v, 8'h00);
    check("R2 irq", {7'd0, irq}, 8'h00);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_event_fall();
    logic [7:0] v;
    wr(2'd0, 8'h01);
    set_pin(1'b1);
    rd(2'd1, v); check("R3 rise ignored", v, 8'h00);
    rd(2'd2, v); check("R6 no flag on rise", v, 8'h00);
    set_pin(1'b0);
    pulses(2);
    rd(2'd1, v); check("R3 falls counted", v, 8'h03);
    rd(2'd2, v); check("R6 edge flag", v, 8'h02);
    wr(2'd2, 8'h00);
    rd(2'd2, v); check("R8 write 0 keeps", v, 8'h02);
    wr(2'd2, 8'h02);
    rd(2'd2, v); check("R8 write 1 clears", v, 8'h00);
  endtask

  task automatic t_event_rise();
    logic [7:0] v;
    wr(2'd0, 8'h05);
    wr(2'd1, 8'h00);
    rd(2'd1, v); check("R10 preload", v, 8'h00);
    set_pin(1'b1);
    rd(2'd1, v); check("R4 rise counted", v, 8'h01);
    set_pin(1'b0);
    rd(2'd1, v); check("R4 fall ignored", v, 8'h01);
    pulses(2);
    rd(2'd1, v); check("R4 total", v, 8'h03);
    wr(2'd2, 8'h03);
  endtask

  task automatic t_overflow_irq();
    logic [7:0] v;
    wr(2'd0, 8'h01);
    wr(2'd1, 8'hFE);
    wr(2'd3, 8'h01);
    pulses(1);
    rd(2'd2, v); check("R7 no ovf at FF", v & 8'h01, 8'h00);
    check("R9 irq low", {7'd0, irq}, 8'h00);
    pulses(1);
    rd(2'd1, v); check("R7 wrapped", v, 8'h00);
    rd(2'd2, v); check("R7 ovf flag", v, 8'h03);
    check("R9 irq ovf", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h01);
    rd(2'd2, v); check("R8 ovf cleared", v, 8'h02);
    check("R9 edge masked", {7'd0, irq}, 8'h00);
    wr(2'd3, 8'h02);
    check("R9 irq edge", {7'd0, irq}, 8'h01);
    wr(2'd2, 8'h03);
    check("R9 irq after clear", {7'd0, irq}, 8'h00);
    wr(2'd3, 8'h00);
  endtask

  task automatic t_gated_high();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    set_pin(1'b1);
    wr(2'd0, 8'h03);
    idle(64 * 5 + 8);
    rd(2'd1, v); check("R5 gated high count", v, 8'h05);
    rd(2'd2, v); check("R6 no flag mid interval", v, 8'h00);
    set_pin(1'b0);
    rd(2'd2, v); check("R6 trailing fall", v, 8'h02);
    idle(200);
    rd(2'd1, v); check("R5 inactive holds", v, 8'h05);
    wr(2'd2, 8'h03);
  endtask

  task automatic t_gated_low();
    logic [7:0] v;
    wr(2'd0, 8'h00);
    wr(2'd1, 8'h00);
    wr(2'd0, 8'h07);
    idle(64 * 3 + 8);
    rd(2'd1, v); check("R5 gated low count", v, 8'h03);
    set_pin(1'b1);
    rd(2'd2, v); check("R6 trailing rise", v, 8'h02);
    idle(200);
    rd(2'd1, v); check("R5 high inactive", v, 8'h03);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_disabled();
    t_event_fall();
    t_event_rise();
    t_overflow_irq();
    t_gated_high();
    t_gated_low();
    done = 1'b1;
  end

  initial begin
    for (int i = 0; i < 100000; i++) begin
      @(posedge clk);
      if (done) break;
    end
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: got timeout expected completion");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule